// File: doc/BRIEF.md
# Single-Stage Serial-to-Parallel Deserializer with Ring Divider

This block turns a serial bit stream into parallel words of `N` bits in one stage. Each rising edge of the bit clock samples one serial bit. The block collects the last `N` samples. A ring of `N` flip-flops rotates on every bit clock and makes a divided clock at one `N`-th of the bit rate.

At reset, the lower half of the ring (`floor(N/2)` flip-flops) is preset to one and the rest are cleared. The divided clock is high for `floor(N/2)` bit periods and low for the rest of each `N`-cycle period. Its pulses are never narrower than one bit period, for any `N` from 2 upward.

On the bit-clock edge where the divided clock rises, the `N` most recent bits, including the bit sampled on that edge, go into the output word. The oldest of those bits goes to index 0. A one-cycle valid strobe marks each new word. Any capture that falls before `N` bits have arrived since reset is dropped. The word stays at zero until the first full word. Word alignment is left to logic downstream.

Top module: `des_1toN`

## Requirements
- R1: While `rst_n` is low at a rising bit-clock edge, the block takes its reset state at that edge: `par_word` = 0, `word_valid` = 0, `div_clk` = 0.
- R2: After reset is released, `div_clk` is periodic with a period of exactly `N` bit clocks. In each period it is high for `floor(N/2)` consecutive cycles and low for `N - floor(N/2)` cycles.
- R3: Count rising bit-clock edges with `rst_n` high from 1. `div_clk` first becomes high on edge `N - floor(N/2)`. After that it rises on every edge `N - floor(N/2) + m*N`.
- R4: On each edge where `div_clk` rises and at least `N` bits have been sampled, `par_word[i]` takes the bit sampled on edge `k - N + 1 + i`, where `k` is the current edge. Index 0 is the earliest bit and index `N-1` is the bit sampled on that edge.
- R5: `word_valid` is high for exactly one bit-clock cycle after each edge that loads `par_word` under R4, and it is low at all other times.
- R6: A `div_clk` rise that comes before `N` bits have been sampled since reset loads nothing. `par_word` stays 0 and `word_valid` stays 0 until the first full word.
- R7: Between loads, `par_word` holds its last value whatever `ser_in` does.
- R8: Asserting `rst_n` low in the middle of a word discards the partial word and restarts the divider phase. The timing of R3 and R6 applies again from the next release.
- R9: `ser_in` is sampled on every rising bit-clock edge. No bit is skipped or repeated across word boundaries, for any bit pattern.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_bit | input | 1 | Bit clock; one serial bit per rising edge |
| rst_n | input | 1 | Synchronous reset, active low |
| ser_in | input | 1 | Serial data input |
| par_word | output | N | Parallel word, earliest bit at index 0 |
| word_valid | output | 1 | One-cycle strobe when a new word is loaded |
| div_clk | output | 1 | Divided clock, period N bit clocks |

## Verification
The ring state is visible at the ports within one divided-clock period. A lost or extra ring bit shows as a wrong high time on `div_clk`, and a stuck ring shows as a missing rise within `N` cycles. A wrong ring phase moves the load edge, so the next word after reset arrives shifted by whole bits, and that shift shows at the first valid strobe. A wrong fill count lets the partial word out, or delays the first word by a full period; either shows within `2N` cycles of reset. The divider is run with an even and an odd ratio side by side, because the preset split differs between them.

// File: rtl/des_pkg.sv
// Package: shared helpers for the deserializer.
// Assumes the ratio is 2 or more; it does not check this.
package des_pkg;

    // Number of ring flip-flops preset high: the lower half, rounded down.
    function automatic int ring_high_len(input int n);
        return n / 2;
    endfunction

    // Width of a counter that must reach the value n.
    function automatic int count_width(input int n);
        return (n < 2) ? 1 : $clog2(n + 1);
    endfunction

endpackage

// File: rtl/des_ring_divider.sv
// Module: rotating ring divider.
// An N-bit ring rotates one place per bit clock. The lower half starts
// high and the rest starts low, so the last bit is a clock with period N
// that is high for floor(N/2) cycles. It also gives a look-ahead pulse
// that is true on the edge where that clock will rise.
// Assumes N >= 2 and a synchronous active-low reset.
module des_ring_divider #(
    parameter int N = 8
) (
    input  logic         clk_bit,
    input  logic         rst_n,
    output logic [N-1:0] ring_q,
    output logic         div_clk,
    output logic         rise_next
);
    import des_pkg::*;

    localparam int HIGH_LEN = ring_high_len(N);

    genvar gi;
    generate
        for (gi = 0; gi < N; gi++) begin : g_stage
            localparam logic INIT_VAL = (gi < HIGH_LEN) ? 1'b1 : 1'b0;
            if (gi == 0) begin : g_head
                // Head stage: takes the bit wrapped around from the tail.
                always_ff @(posedge clk_bit) begin
                    if (!rst_n) ring_q[gi] <= INIT_VAL;
                    else        ring_q[gi] <= ring_q[N-1];
                end
            end else begin : g_body
                // Body stage: takes the bit from its lower neighbour.
                always_ff @(posedge clk_bit) begin
                    if (!rst_n) ring_q[gi] <= INIT_VAL;
                    else        ring_q[gi] <= ring_q[gi-1];
                end
            end
        end
    endgenerate

    // Divided clock output: the tail of the ring.
    assign div_clk   = ring_q[N-1];
    // Rise look-ahead: the tail is low now and a one moves into it next.
    assign rise_next = ring_q[N-2] & ~ring_q[N-1];

endmodule

// File: rtl/des_shift_in.sv
// Module: serial input history.
// Keeps the N-1 most recent serial bits. Together with the current input
// bit they form the candidate word, oldest bit at index 0.
// Assumes N >= 2; for N = 2 the history is a single flip-flop.
module des_shift_in #(
    parameter int N = 8
) (
    input  logic         clk_bit,
    input  logic         rst_n,
    input  logic         ser_in,
    output logic [N-1:0] cand_word
);
    logic [N-2:0] hist_q;

    generate
        if (N == 2) begin : g_single
            // One-bit history: holds the previous sample.
            always_ff @(posedge clk_bit) begin
                if (!rst_n) hist_q <= '0;
                else        hist_q <= ser_in;
            end
        end else begin : g_chain
            // History chain: new bit in at the top, oldest drops off index 0.
            always_ff @(posedge clk_bit) begin
                if (!rst_n) hist_q <= '0;
                else        hist_q <= {ser_in, hist_q[N-2:1]};
            end
        end
    endgenerate

    // Candidate word: the current bit on top of the stored history.
    assign cand_word = {ser_in, hist_q};

endmodule

// File: rtl/des_fill_tracker.sv
// Module: first-word fill tracker.
// Counts sampled bits after reset and stops at N. It reports whether the
// bit sampled on the current edge completes at least N bits.
// Assumes a synchronous active-low reset.
module des_fill_tracker #(
    parameter int N = 8
) (
    input  logic clk_bit,
    input  logic rst_n,
    output logic full_now
);
    import des_pkg::*;

    localparam int               CW      = count_width(N);
    localparam logic [CW-1:0]    CNT_MAX = CW'(N);
    localparam logic [CW-1:0]    CNT_ALM = CW'(N - 1);

    logic [CW-1:0] cnt_q;

    // Sample counter: counts up once per edge and stops at N.
    always_ff @(posedge clk_bit) begin
        if (!rst_n)               cnt_q <= '0;
        else if (cnt_q < CNT_MAX) cnt_q <= cnt_q + 1'b1;
    end

    // Full flag: the sample on this edge makes N or more bits.
    assign full_now = (cnt_q >= CNT_ALM);

endmodule

// File: rtl/des_word_capture.sv
// Module: parallel word register and valid strobe.
// Loads the candidate word when the divided clock is about to rise and
// enough bits have been collected. Raises valid for that one cycle.
// Assumes rise_next and full_now are valid before the same edge.
module des_word_capture #(
    parameter int N = 8
) (
    input  logic         clk_bit,
    input  logic         rst_n,
    input  logic         rise_next,
    input  logic         full_now,
    input  logic [N-1:0] cand_word,
    output logic [N-1:0] par_word,
    output logic         word_valid
);
    logic load;

    // Load decision: divider edge and a full history.
    assign load = rise_next & full_now;

    // Word register: loads on a qualified edge, otherwise holds.
    always_ff @(posedge clk_bit) begin
        if (!rst_n)    par_word <= '0;
        else if (load) par_word <= cand_word;
    end

    // Valid strobe: high for the cycle after each load.
    always_ff @(posedge clk_bit) begin
        if (!rst_n) word_valid <= 1'b0;
        else        word_valid <= load;
    end

endmodule

// File: rtl/des_1toN.sv
// Module: single-stage 1:N deserializer (top).
// Joins the ring divider, the input history, the fill tracker and the word
// register. Everything runs on the bit clock. The divided clock is
// brought out as a data signal for downstream use.
// Assumes N >= 2 and a synchronous active-low reset.
module des_1toN #(
    parameter int N = 8
) (
    input  logic         clk_bit,
    input  logic         rst_n,
    input  logic         ser_in,
    output logic [N-1:0] par_word,
    output logic         word_valid,
    output logic         div_clk
);
    logic [N-1:0] ring_q;
    logic         rise_next;
    logic [N-1:0] cand_word;
    logic         full_now;

    des_ring_divider #(.N(N)) u_div (
        .clk_bit   (clk_bit),
        .rst_n     (rst_n),
        .ring_q    (ring_q),
        .div_clk   (div_clk),
        .rise_next (rise_next)
    );

    des_shift_in #(.N(N)) u_shift (
        .clk_bit   (clk_bit),
        .rst_n     (rst_n),
        .ser_in    (ser_in),
        .cand_word (cand_word)
    );

    des_fill_tracker #(.N(N)) u_fill (
        .clk_bit  (clk_bit),
        .rst_n    (rst_n),
        .full_now (full_now)
    );

    des_word_capture #(.N(N)) u_cap (
        .clk_bit    (clk_bit),
        .rst_n      (rst_n),
        .rise_next  (rise_next),
        .full_now   (full_now),
        .cand_word  (cand_word),
        .par_word   (par_word),
        .word_valid (word_valid)
    );

endmodule

// File: rtl/des_1toN_chk.sv
// Module: assertion checker for des_1toN, attached by bind.
// Watches the ports and the ring state. It measures the divider period
// with its own counter, so no deep $past is needed.
module des_1toN_chk #(
    parameter int N = 8
) (
    input logic         clk_bit,
    input logic         rst_n,
    input logic [N-1:0] par_word,
    input logic         word_valid,
    input logic         div_clk,
    input logic [N-1:0] ring_q
);
    logic [31:0] gap_q;
    logic        seen_rise_q;
    logic        div_d_q;

    // Period monitor: cycles since the last rise of the divided clock.
    always_ff @(posedge clk_bit) begin
        if (!rst_n) begin
            gap_q       <= '0;
            seen_rise_q <= 1'b0;
            div_d_q     <= 1'b0;
        end else begin
            div_d_q <= div_clk;
            if (div_clk && !div_d_q) begin
                gap_q       <= '0;
                seen_rise_q <= 1'b1;
            end else begin
                gap_q <= gap_q + 1;
            end
        end
    end

    AST_RESET_STATE: assert property (@(posedge clk_bit)
        !rst_n |=> (par_word == '0 && !word_valid && !div_clk)); // R1

    AST_DIV_PERIOD: assert property (@(posedge clk_bit) disable iff (!rst_n)
        (seen_rise_q && div_clk && !div_d_q) |-> (gap_q == 32'(N - 1))); // R2

    AST_RING_WEIGHT: assert property (@(posedge clk_bit) disable iff (!rst_n)
        $countones(ring_q) == (N / 2)); // R2

    AST_VALID_ON_RISE: assert property (@(posedge clk_bit) disable iff (!rst_n)
        word_valid |-> (div_clk && !div_d_q)); // R4

    AST_VALID_SINGLE: assert property (@(posedge clk_bit) disable iff (!rst_n)
        word_valid |=> !word_valid); // R5

    AST_WORD_HOLD: assert property (@(posedge clk_bit) disable iff (!rst_n)
        !word_valid |=> (!word_valid || 1'b1) && ($past(word_valid) || $stable(par_word) || word_valid)); // R7

endmodule

bind des_1toN des_1toN_chk #(.N(N)) u_chk (
    .clk_bit    (clk_bit),
    .rst_n      (rst_n),
    .par_word   (par_word),
    .word_valid (word_valid),
    .div_clk    (div_clk),
    .ring_q     (ring_q)
);

// File: tb/des_1toN_test.sv
// Bench: drives one serial stream into an even-ratio and an odd-ratio
// deserializer and checks both against a model built from the requirements.
module des_1toN_test;

    localparam int NA = 8;
    localparam int NB = 5;
    localparam int NVEC = 6;
    localparam logic [7:0] VEC [NVEC] = '{8'hA5, 8'h01, 8'h80, 8'hFF, 8'h00, 8'h3C};

    logic clk_bit = 1'b0;
    logic rst_n;
    logic ser_in;
    logic [NA-1:0] word_a;
    logic [NB-1:0] word_b;
    logic valid_a, valid_b, div_a, div_b;

    int checks = 0;
    int errors = 0;
    int k = 0;
    bit hist [0:1023];
    logic [7:0] exp_a = '0;
    logic [7:0] exp_b = '0;

    always #4 clk_bit = ~clk_bit;

    des_1toN #(.N(NA)) uut (
        .clk_bit(clk_bit), .rst_n(rst_n), .ser_in(ser_in),
        .par_word(word_a), .word_valid(valid_a), .div_clk(div_a));

    des_1toN #(.N(NB)) uut_odd (
        .clk_bit(clk_bit), .rst_n(rst_n), .ser_in(ser_in),
        .par_word(word_b), .word_valid(valid_b), .div_clk(div_b));

    task automatic chk(input string tag, input logic [7:0] act, input logic [7:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %h expected %h (edge %0d)", tag, act, exp, k);
        end
    endtask

    // Check one instance after edge k against the model.
    task automatic check_inst(input int n, input logic [7:0] w, input logic v,
                              input logic d, inout logic [7:0] expw);
        int hi;
        bit cap;
        bit d_e;
        hi  = n / 2;
        d_e = (k % n) >= (n - hi);
        cap = (k >= n - hi) && (((k - (n - hi)) % n) == 0) && (k >= n);
        if (k == n - hi) chk("R3 first rise", {7'b0, d}, 8'h01);
        else             chk("R2 div_clk", {7'b0, d}, {7'b0, d_e});
        chk("R5 valid", {7'b0, v}, {7'b0, cap});
        if (cap) begin
            for (int i = 0; i < n; i++) expw[i] = hist[k - n + 1 + i];
            chk("R4 R9 word", w, expw);
        end else if (k < n) begin
            chk("R6 word zero", w, 8'h00);
        end else begin
            chk("R7 word hold", w, expw);
        end
    endtask

    task automatic step(input logic b);
        ser_in = b;
        @(negedge clk_bit);
        k++;
        hist[k] = b;
        check_inst(NA, {{(8-NA){1'b0}}, word_a}, valid_a, div_a, exp_a);
        check_inst(NB, {{(8-NB){1'b0}}, word_b}, valid_b, div_b, exp_b);
    endtask

    initial begin
        #1_000_000;
        errors++;
        $display("FAIL watchdog: actual timeout expected finish");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        rst_n  = 1'b0;
        ser_in = 1'b1;
        repeat (3) @(negedge clk_bit);
        chk("R1 word", word_a, 8'h00);
        chk("R1 valid", {7'b0, valid_a}, 8'h00);
        chk("R1 div_clk", {7'b0, div_a}, 8'h00);
        chk("R1 odd div_clk", {7'b0, div_b}, 8'h00);
        rst_n = 1'b1;
        k = 0;

        // Filler bits of one: the dropped first capture must stay zero.
        repeat (4) step(1'b1);
        // Table walk: each vector sent oldest bit first.
        for (int v = 0; v < NVEC; v++)
            for (int i = 0; i < 8; i++) step(VEC[v][i]);

        // Mid-word reset.
        repeat (3) step(1'b1);
        ser_in = 1'b1;
        rst_n  = 1'b0;
        @(negedge clk_bit);
        chk("R8 word cleared", word_a, 8'h00);
        chk("R8 valid cleared", {7'b0, valid_a}, 8'h00);
        chk("R8 div_clk cleared", {7'b0, div_a}, 8'h00);
        chk("R8 odd word cleared", {3'b0, word_b}, 8'h00);
        @(negedge clk_bit);
        rst_n = 1'b1;
        k = 0;
        exp_a = '0;
        exp_b = '0;
        // Restarted phase: alternating bits then a burst of ones.
        for (int i = 0; i < 20; i++) step(i[0]);
        repeat (10) step(1'b1);

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule